// File: doc/BRIEF.md
# Banked Latency Memory Responder

This block stands in for memory on the slave side of an AXI-style bus, so that a bus master can be verified against a realistic memory. It takes single-beat writes on a combined address/data write path and single-beat reads on the read address path. A write lands in the internal store at once, and only the byte lanes its strobe enables are changed. A read takes a copy of the addressed block when it is accepted and waits in a per-bank queue until a fixed latency has passed. Banks are interleaved on block address.

Finished reads go back one at a time on the read data channel, with the request's ID. When several banks have a finished read at their head, they are served in rotating order. A read to an address that is already waiting in the same bank takes over the remaining delay of that earlier read. The responder can hold off the master with stalls injected on a fixed period, and it also stalls when the target bank's queue is full.

All data paths are valid/ready. A request is taken only on a clock edge where valid and ready are both high. A master may hold valid high while ready is low, and the request then waits. On the response channel, `rvalid` stays high with `rid` and `rdata` unchanged until `rready` is seen high at a clock edge.

Top module: `lat_mem_slave`

## Requirements
- R1: While `rst_n` is low, `awready`, `wready`, `arready` and `rvalid` are all low, and every bank queue is empty once reset is released.
- R2: With stall injection enabled, the ready outputs are low in every cycle whose index c satisfies (c / 2) mod STALL_PERIOD == 0. The index c counts clock edges since reset release, and the cycle after release is c = 0.
- R3: The ready outputs are low while the target bank's queue already holds Q_DEPTH entries. The target bank is taken from `awaddr` when `wvalid` is high and from `araddr` otherwise.
- R4: An accepted write changes byte lane i of the addressed block (bits 8i+7..8i) only where `wstrb[i]` is 1.
- R5: While `wvalid` is high, `arready` is low, so a write presented together with a read is taken first.
- R6: A read accepted at a clock edge, into an empty bank queue with the response slot free and `rready` high, raises `rvalid` exactly LATENCY edges later.
- R7: A read whose address matches an entry already waiting in the same bank queue takes that entry's remaining countdown instead of the full LATENCY.
- R8: Among banks whose oldest entry is due, the next response comes from the first one found when scanning upward from one past the bank served last, wrapping at NUM_BANKS.
- R9: While `rvalid` is high and `rready` is low, `rvalid`, `rid` and `rdata` hold their values.
- R10: Each response carries the request's ID on `rid` and the block contents as they were at acceptance. Reads within one bank return in acceptance order.
- R11: The bank of an address is (address / (DATA_W/8)) mod NUM_BANKS, so a full queue in one bank does not stall requests aimed at another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| awvalid | input | 1 | Write address valid |
| awaddr | input | ADDR_W | Write byte address, block aligned |
| wvalid | input | 1 | Write data valid; marks the request as a write |
| wdata | input | DATA_W | Write block data |
| wstrb | input | DATA_W/8 | Write byte-lane enables |
| awready | output | 1 | Write address ready |
| wready | output | 1 | Write data ready |
| arvalid | input | 1 | Read address valid |
| araddr | input | ADDR_W | Read byte address, block aligned |
| arid | input | ID_W | Read request ID |
| arready | output | 1 | Read address ready |
| rvalid | output | 1 | Read response valid |
| rid | output | ID_W | ID of the returned read |
| rdata | output | DATA_W | Returned block data |
| rready | input | 1 | Master accepts the read response |

## Verification
The properties assume a master that raises `awvalid` and `wvalid` together and keeps addresses block aligned. They also assume it never drops a presented read before it is taken, so a bank counter can only move through real pushes and due pops. The stimulus drives each request from just after a rising edge and holds it until ready is seen, then withdraws it on the next edge. The one exception is the full-queue probe, which presents and then withdraws a read between two edges, before any edge could take it. IDs are reused only after the earlier read with that ID has returned.

// File: rtl/lms_pkg.sv
package lms_pkg;

  // What the responder does with the request offered in the current cycle.
  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_WRITE = 2'd1,
    REQ_READ  = 2'd2
  } req_kind_e;

endpackage

// File: rtl/lms_stall_gen.sv
module lms_stall_gen #(
  parameter int STALL_EN     = 1,
  parameter int STALL_PERIOD = 8,
  parameter int CYC_W        = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic inject
);

  generate
    if (STALL_EN != 0) begin : g_on
      localparam logic [CYC_W-1:0] PER = CYC_W'(STALL_PERIOD);
      logic [CYC_W-1:0] cyc_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_q + 1'b1;
      end

      // Two-cycle stall window once every STALL_PERIOD pairs of cycles.
      assign inject = ((cyc_q >> 1) % PER) == '0;
    end else begin : g_off
      assign inject = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/lms_store.sv
module lms_store #(
  parameter int NBLK   = 64,
  parameter int DATA_W = 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int IDX_W  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BYTES-1:0]  wstrb,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [NBLK];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wstrb[b]) mem[widx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/lms_bank_q.sv
module lms_bank_q #(
  parameter int DEPTH   = 4,
  parameter int TAG_W   = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int LATENCY = 12,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W  = $clog2(DEPTH + 1),
  localparam int LAT_W  = $clog2(LATENCY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              head_due,
  output logic [TAG_W-1:0]  head_tag,
  output logic [DATA_W-1:0] head_data,
  output logic [OCC_W-1:0]  occ,
  output logic              full
);

  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [LAT_W-1:0]  cnt_q  [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [OCC_W-1:0]  occ_q;

  logic              hit;
  logic [LAT_W-1:0]  hit_cnt;
  logic [LAT_W-1:0]  push_cnt;

  function automatic logic [PTR_W-1:0] ptr_add(input logic [PTR_W-1:0] p, input int unsigned k);
    int unsigned s;
    s = 32'(p) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  function automatic logic [LAT_W-1:0] tick(input logic [LAT_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  // Oldest live entry with the same address; the head leaving this cycle is
  // not counted. Its value after this edge's decrement is inherited.
  always_comb begin
    logic [PTR_W-1:0] idx;
    hit     = 1'b0;
    hit_cnt = '0;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      idx = ptr_add(rd_ptr, 32'(j));
      if ((32'(j) < 32'(occ_q)) && !(pop && (j == 0)) && (addr_q[idx] == push_addr)) begin
        hit     = 1'b1;
        hit_cnt = tick(cnt_q[idx]);
      end
    end
  end

  assign push_cnt = hit ? hit_cnt : LAT_W'(LATENCY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ_q  <= '0;
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= tick(cnt_q[i]);
      if (push) begin
        cnt_q[wr_ptr] <= push_cnt;
        wr_ptr        <= ptr_add(wr_ptr, 1);
      end
      if (pop) rd_ptr <= ptr_add(rd_ptr, 1);
      occ_q <= occ_q + OCC_W'(push) - OCC_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      tag_q[wr_ptr]  <= push_tag;
      addr_q[wr_ptr] <= push_addr;
      data_q[wr_ptr] <= push_data;
    end
  end

  // Due when the count reaches zero at this edge's decrement.
  assign head_due  = (occ_q != '0) && (cnt_q[rd_ptr] <= LAT_W'(1));
  assign head_tag  = tag_q[rd_ptr];
  assign head_data = data_q[rd_ptr];
  assign occ       = occ_q;
  assign full      = (occ_q == OCC_W'(DEPTH));

endmodule

// File: rtl/lms_rr_pick.sv
module lms_rr_pick #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] last,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] gidx,
  output logic             any
);

  always_comb begin
    int unsigned pos;
    grant = '0;
    gidx  = '0;
    any   = 1'b0;
    // Walk from farthest to nearest so the nearest requester after 'last' wins.
    for (int k = N; k >= 1; k--) begin
      pos = (32'(last) + 32'(k)) % N;
      if (req[pos]) begin
        grant      = '0;
        grant[pos] = 1'b1;
        gidx       = IDX_W'(pos);
        any        = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lat_mem_slave.sv
module lat_mem_slave #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 32,
  parameter int ID_W         = 4,
  parameter int NUM_BANKS    = 4,
  parameter int Q_DEPTH      = 4,
  parameter int LATENCY      = 12,
  parameter int MEM_BYTES    = 256,
  parameter int STALL_EN     = 1,
  parameter int STALL_PERIOD = 8,
  parameter int CYC_W        = 16,
  localparam int STRB_W      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  output logic              awready,
  output logic              wready,
  input  logic              arvalid,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [ID_W-1:0]   arid,
  output logic              arready,
  output logic              rvalid,
  output logic [ID_W-1:0]   rid,
  output logic [DATA_W-1:0] rdata,
  input  logic              rready
);
  import lms_pkg::*;

  localparam int BLK_SHIFT = $clog2(STRB_W);
  localparam int NBLK      = MEM_BYTES / STRB_W;
  localparam int MIDX_W    = (NBLK > 1) ? $clog2(NBLK) : 1;
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int OCC_W     = $clog2(Q_DEPTH + 1);

  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] blk;
    blk = a >> BLK_SHIFT;
    if (NUM_BANKS < 2) return '0;
    return BANK_W'(blk % ADDR_W'(NUM_BANKS));
  endfunction

  // ---------------- request side ----------------
  logic                 inject;
  logic [NUM_BANKS-1:0] full_v;
  logic [NUM_BANKS-1:0] elig_v;
  logic [BANK_W-1:0]    tgt_bank, rd_bank;
  logic                 tgt_full, stall;
  logic                 wr_acc, rd_acc;
  req_kind_e            kind;
  logic [DATA_W-1:0]    snap_data;

  lms_stall_gen #(
    .STALL_EN    (STALL_EN),
    .STALL_PERIOD(STALL_PERIOD),
    .CYC_W       (CYC_W)
  ) u_stall (
    .clk   (clk),
    .rst_n (rst_n),
    .inject(inject)
  );

  assign tgt_bank = bank_of(wvalid ? awaddr : araddr);
  assign rd_bank  = bank_of(araddr);
  assign tgt_full = full_v[tgt_bank];
  assign stall    = inject | tgt_full;

  assign awready = rst_n & ~stall;
  assign wready  = rst_n & ~stall;
  assign arready = rst_n & ~stall & ~wvalid;

  assign wr_acc = wvalid & awvalid & awready;
  assign rd_acc = arvalid & arready;

  always_comb begin
    if (wr_acc)      kind = REQ_WRITE;
    else if (rd_acc) kind = REQ_READ;
    else             kind = REQ_NONE;
  end

  lms_store #(
    .NBLK  (NBLK),
    .DATA_W(DATA_W)
  ) u_store (
    .clk  (clk),
    .we   (kind == REQ_WRITE),
    .widx (MIDX_W'(awaddr >> BLK_SHIFT)),
    .wdata(wdata),
    .wstrb(wstrb),
    .ridx (MIDX_W'(araddr >> BLK_SHIFT)),
    .rdata(snap_data)
  );

  // ---------------- bank queues ----------------
  logic [ID_W-1:0]          htag  [NUM_BANKS];
  logic [DATA_W-1:0]        hdata [NUM_BANKS];
  logic [NUM_BANKS-1:0]     pop_v;
  logic [NUM_BANKS*OCC_W-1:0] occ_flat;

  logic [NUM_BANKS-1:0] rr_grant;
  logic [BANK_W-1:0]    rr_idx, last_q;
  logic                 rr_any;
  logic                 slot_free, load;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [OCC_W-1:0] occ_b;
      lms_bank_q #(
        .DEPTH  (Q_DEPTH),
        .TAG_W  (ID_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LATENCY(LATENCY)
      ) u_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     ((kind == REQ_READ) && (rd_bank == BANK_W'(b))),
        .push_tag (arid),
        .push_addr(araddr),
        .push_data(snap_data),
        .pop      (pop_v[b]),
        .head_due (elig_v[b]),
        .head_tag (htag[b]),
        .head_data(hdata[b]),
        .occ      (occ_b),
        .full     (full_v[b])
      );
      assign occ_flat[b*OCC_W +: OCC_W] = occ_b;
      assign pop_v[b] = load & rr_grant[b];
    end
  endgenerate

  // ---------------- response side ----------------
  lms_rr_pick #(
    .N(NUM_BANKS)
  ) u_rr (
    .req  (elig_v),
    .last (last_q),
    .grant(rr_grant),
    .gidx (rr_idx),
    .any  (rr_any)
  );

  assign slot_free = ~rvalid | rready;
  assign load      = slot_free & rr_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rid    <= '0;
      rdata  <= '0;
      last_q <= '0;
    end else if (slot_free) begin
      rvalid <= rr_any;
      if (rr_any) begin
        rid    <= htag[rr_idx];
        rdata  <= hdata[rr_idx];
        last_q <= rr_idx;
      end
    end
  end

endmodule

// File: rtl/lms_chk.sv
module lms_chk #(
  parameter int NUM_BANKS = 4,
  parameter int OCC_W     = 3,
  parameter int Q_DEPTH   = 4,
  parameter int ID_W      = 4,
  parameter int DATA_W    = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rvalid,
  input logic                       rready,
  input logic [ID_W-1:0]            rid,
  input logic [DATA_W-1:0]          rdata,
  input logic                       awready,
  input logic                       wready,
  input logic                       arready,
  input logic [NUM_BANKS-1:0]       elig,
  input logic [NUM_BANKS-1:0]       grant,
  input logic [NUM_BANKS*OCC_W-1:0] occ_flat
);

  logic seen_rst = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n && seen_rst) begin
      p_reset_quiet_r1: assert (!rvalid && !awready && !wready && !arready)
        else $error("outputs active during reset");
    end
    if (!rst_n) seen_rst <= 1'b1;
  end

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_occ
      p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occ_flat[b*OCC_W +: OCC_W] <= OCC_W'(Q_DEPTH))
        else $error("bank queue overfilled");
    end
  endgenerate

  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant))
    else $error("more than one bank granted");

  p_grant_due_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~elig) == '0)
    else $error("grant to a bank with nothing due");

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rid) && $stable(rdata))
    else $error("response changed while stalled");

  p_rsp_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rvalid || rready) && (elig != '0) |=> rvalid)
    else $error("due read not loaded into free slot");

endmodule

bind lat_mem_slave lms_chk #(
  .NUM_BANKS(NUM_BANKS),
  .OCC_W    (OCC_W),
  .Q_DEPTH  (Q_DEPTH),
  .ID_W     (ID_W),
  .DATA_W   (DATA_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rvalid  (rvalid),
  .rready  (rready),
  .rid     (rid),
  .rdata   (rdata),
  .awready (awready),
  .wready  (wready),
  .arready (arready),
  .elig    (elig_v),
  .grant   (rr_grant),
  .occ_flat(occ_flat)
);

// File: tb/lat_mem_slave_test.sv
`timescale 1ns/1ps
module lat_mem_slave_test;

  localparam int LAT = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0, rready = 1'b0;
  logic [15:0] awaddr = '0, araddr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0, arid = '0;
  logic        awready, wready, arready, rvalid;
  logic [3:0]  rid;
  logic [31:0] rdata;

  lat_mem_slave uut (
    .clk(clk), .rst_n(rst_n),
    .awvalid(awvalid), .awaddr(awaddr), .wvalid(wvalid), .wdata(wdata), .wstrb(wstrb),
    .awready(awready), .wready(wready),
    .arvalid(arvalid), .araddr(araddr), .arid(arid), .arready(arready),
    .rvalid(rvalid), .rid(rid), .rdata(rdata), .rready(rready)
  );

  always #2.5 clk = ~clk;

  int bcyc = 0;
  always @(posedge clk) begin
    if (!rst_n) bcyc <= 0;
    else        bcyc <= bcyc + 1;
  end

  int checks = 0, errors = 0;
  typedef struct { logic [3:0] id; logic [31:0] data; } exp_t;
  exp_t exp_q[$];
  logic [31:0] bm [64];

  function automatic bit inj(int c);
    return ((c / 2) % 8) == 0;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: every accepted response is compared in order.
  always @(negedge clk) begin
    if (rst_n && rvalid && rready) begin
      if (exp_q.size() == 0) chk("R10", "unexpected response id", rid, 16'hFFFF);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R10", "response id", rid, e.id);
        chk("R10", "response data", rdata, e.data);
      end
    end
  end

  // Tasks start just after a rising edge and return just after one.
  task automatic do_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s);
    awvalid = 1; wvalid = 1; awaddr = a; wdata = d; wstrb = s;
    @(negedge clk);
    while (!(awready && wready)) @(negedge clk);
    @(posedge clk); #1;
    awvalid = 0; wvalid = 0;
    for (int b = 0; b < 4; b++) if (s[b]) bm[a[7:2]][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic do_read(input logic [15:0] a, input logic [3:0] id, input bit push, output int acc);
    exp_t e;
    arvalid = 1; araddr = a; arid = id;
    @(negedge clk);
    while (!arready) @(negedge clk);
    e.id = id; e.data = bm[a[7:2]];
    @(posedge clk); #1;
    arvalid = 0;
    acc = bcyc;
    if (push) exp_q.push_back(e);
  endtask

  task automatic wait_rsp(input logic [3:0] id, output int t);
    @(negedge clk);
    while (!(rvalid && rid == id)) @(negedge clk);
    t = bcyc;
    @(posedge clk); #1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a1, a2, t1, t2, dummy;
    logic [3:0] hold_id;
    exp_t e;

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R1", "rvalid in reset", rvalid, 0);
      chk("R1", "awready in reset", awready, 0);
      chk("R1", "arready in reset", arready, 0);
    end
    @(posedge clk); #1; rst_n = 1;

    // R2: injected stall pattern with idle queues
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk("R2", "awready vs stall period", awready, !inj(bcyc));
      chk("R2", "arready vs stall period", arready, !inj(bcyc));
    end
    @(posedge clk); #1;

    for (int i = 0; i < 32; i++) do_write(16'(i * 4), 32'h5A00_0000 + 32'(i * 32'h0101), 4'hF);

    // R6: latency into empty queue
    rready = 1;
    do_read(16'h0008, 4'd1, 1, a1);
    wait_rsp(4'd1, t1);
    chk("R6", "read latency", t1 - a1, LAT);
    drain();

    // R7: repeat read inherits remaining delay
    do_read(16'h0010, 4'd2, 1, a1);
    repeat (4) @(posedge clk); #1;
    do_read(16'h0010, 4'd3, 1, a2);
    wait_rsp(4'd2, t1);
    chk("R7", "first read return", t1, a1 + LAT);
    wait_rsp(4'd3, t2);
    chk("R7", "repeat read inherits delay", t2, a1 + LAT + 1);
    drain();

    // R4: byte strobes
    do_write(16'h0050, 32'hA1B2_C3D4, 4'hF);
    do_write(16'h0050, 32'h1122_3344, 4'b0101);
    e.id = 4'd4; e.data = 32'hA122_C344;
    do_read(16'h0050, 4'd4, 0, dummy);
    exp_q.push_back(e);
    drain();

    // R5: write beats a read offered with it
    awvalid = 1; wvalid = 1; awaddr = 16'h0054; wdata = 32'hCAFE_0054; wstrb = 4'hF;
    arvalid = 1; araddr = 16'h0058; arid = 4'd5;
    @(negedge clk);
    while (!awready) @(negedge clk);
    chk("R5", "arready while write offered", arready, 0);
    @(posedge clk); #1;
    awvalid = 0; wvalid = 0;
    bm[8'h54 >> 2] = 32'hCAFE_0054;
    do_read(16'h0058, 4'd5, 1, dummy);
    drain();

    // R10: data snapshot taken at acceptance
    do_read(16'h0060, 4'd6, 1, dummy);
    do_write(16'h0060, 32'hDEAD_BEEF, 4'hF);
    do_read(16'h0060, 4'd7, 1, dummy);
    drain();

    // R3 / R11: fill bank 0, probe bank 0 and bank 1
    rready = 0;
    do_read(16'h0000, 4'd8, 1, dummy);
    do_read(16'h0010, 4'd9, 1, dummy);
    do_read(16'h0020, 4'd10, 1, dummy);
    do_read(16'h0030, 4'd11, 1, dummy);
    arvalid = 1; araddr = 16'h0040; arid = 4'd12;
    @(negedge clk);
    while (inj(bcyc)) @(negedge clk);
    chk("R3", "arready with bank 0 full", arready, 0);
    #0.5 araddr = 16'h0044;
    #0.5 chk("R11", "arready for bank 1 while bank 0 full", arready, 1);
    #0.5 arvalid = 0;
    @(posedge clk); #1;
    rready = 1;
    drain();

    // R8 / R9: round-robin return order and response hold
    rready = 0;
    do_read(16'h000C, 4'd13, 0, dummy);   // bank 3
    do_read(16'h0004, 4'd14, 0, dummy);   // bank 1
    do_read(16'h0008, 4'd15, 0, dummy);   // bank 2
    do_read(16'h0000, 4'd0, 0, dummy);    // bank 0
    repeat (20) @(posedge clk);
    @(negedge clk);
    hold_id = rid;
    chk("R9", "rvalid while not ready", rvalid, 1);
    repeat (5) @(negedge clk);
    chk("R9", "rvalid held", rvalid, 1);
    chk("R9", "rid held", rid, hold_id);
    chk("R8", "first due bank served", hold_id, 13);
    @(posedge clk); #1;
    e.id = 4'd13; e.data = bm[8'h0C >> 2]; exp_q.push_back(e);
    e.id = 4'd0;  e.data = bm[8'h00 >> 2]; exp_q.push_back(e);
    e.id = 4'd14; e.data = bm[8'h04 >> 2]; exp_q.push_back(e);
    e.id = 4'd15; e.data = bm[8'h08 >> 2]; exp_q.push_back(e);
    rready = 1;
    drain();
    repeat (4) @(posedge clk);
    chk("R8", "all responses returned", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule